// File: doc/BRIEF.md
# Synchronous Serial Shifter with Selectable Bit Order and Clock Polarity

The block moves one 8-bit word out on a serial data line and, at the same time, takes one 8-bit word in on a serial data input. The same shift register holds both words. The host sees that register as two 4-bit halves at two consecutive addresses. It loads the outgoing word before a transfer, pulses a start strobe, waits for the done flag, and reads the received word back through the same two addresses.

The serial clock can come from either side. In internal mode the block divides the system clock and drives its own serial clock pin, with the output enable asserted. In external mode it releases the pin and follows edges of an incoming clock, which it passes through a two-flop synchronizer before edge detection. A bit-order input chooses whether the most or the least significant bit leaves first; the received bits land in the mirrored positions. A polarity input inverts the idle level and the direction of every edge. Outgoing data changes on the leading edge of each period, and incoming data is captured on the trailing edge.

Top module: `sio_shifter`

## Requirements
- R1: After reset the block is idle: busy and done are low, the data output is 0, the clock output sits at its idle level, and both nibbles read 0.
- R2: Address 0 reads and writes word bits 3..0, and address 1 reads and writes bits 7..4. Read data follows the address with no clock delay, and a write takes effect on the next clock edge.
- R3: In internal mode the clock output enable is high. An accepted start gives the first leading edge HALF_DIV system cycles later. Eight full periods of 2*HALF_DIV cycles follow, and done rises exactly 16*HALF_DIV cycles after the start.
- R4: When msb_first_i is 1, bit 7 is sent first and bit 0 last. The first received bit ends up in bit 7.
- R5: When msb_first_i is 0, bit 0 is sent first and bit 7 last. The first received bit ends up in bit 0.
- R6: With clk_inv_i at 0 the clock idles low and the leading edge rises. With clk_inv_i at 1 the clock idles high and the leading edge falls.
- R7: The data output changes only on leading edges, and the data input is captured only on trailing edges.
- R8: In external mode the clock output enable is low, and edges of sclk_i take effect on the third rising system clock edge after they appear. Edges that arrive while the block is idle do nothing.
- R9: While busy, writes to either nibble and further start pulses are ignored, and the transfer keeps its timing.
- R10: At the end of the eighth trailing edge, busy falls, the clock returns to idle and done rises. Done stays high until clr_done_i or a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_mode_i | input | 1 | 1: follow sclk_i; 0: generate the serial clock internally |
| msb_first_i | input | 1 | 1: most significant bit first; 0: least significant first |
| clk_inv_i | input | 1 | 1: clock idles high (negative logic) |
| addr_i | input | 1 | Nibble select: 0 = bits 3..0, 1 = bits 7..4 |
| wr_en_i | input | 1 | Nibble write strobe |
| wdata_i | input | 4 | Nibble write data |
| rdata_o | output | 4 | Nibble read data for addr_i |
| start_i | input | 1 | Start strobe, taken only when idle |
| clr_done_i | input | 1 | Clears the done flag |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky completion flag |
| sin_i | input | 1 | Serial data input |
| sout_o | output | 1 | Serial data output |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Driven serial clock |
| sclk_oe_o | output | 1 | Clock pin output enable |

## Verification
With HALF_DIV at 2, an internal transfer that starts at clock edge E0 shows its first leading edge at E0+2 and its last trailing edge at E0+32. The bench therefore counts falling edges after the start strobe, expects the first leading edge at count 3 and done at count 33, and checks that done is still low at count 32. At each leading edge it checks the data output in that same half cycle and sets the next input bit before the trailing edge. In external mode a driven clock edge is acted on at the third rising edge, so done is checked low two falling edges after the last trailing drive and high one edge later.

// File: rtl/sio_pkg.sv
package sio_pkg;

   // source of the serial clock
   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;

   // order of bits on the line
   typedef enum logic {
      ORD_LSB = 1'b0,
      ORD_MSB = 1'b1
   } bit_order_e;

   // width of a counter able to hold 0..n-1 (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
   parameter int unsigned HALF_DIV    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic ext_mode_i,
   input  logic clk_inv_i,
   input  logic sclk_i,
   output logic lead_o,
   output logic trail_o,
   output logic phase_o
);
   import sio_pkg::*;

   localparam int unsigned DIV_W = cnt_width(HALF_DIV);

   logic int_tick;
   logic phase_q;

   // internal divider: one tick per half period
   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign int_tick = run_i && (ext_mode_i == SRC_INT);
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         assign int_tick = run_i && (ext_mode_i == SRC_INT)
                           && (div_q == DIV_W'(HALF_DIV - 1));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)               div_q <= '0;
            else if (!run_i || int_tick) div_q <= '0;
            else                       div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       phase_q <= 1'b0;
      else if (!run_i)   phase_q <= 1'b0;
      else if (int_tick) phase_q <= ~phase_q;
   end

   // external clock: synchronizer chain plus one flop for edge detection
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   ext_edge, ext_phase;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= sclk_i;
         end
      end else begin : g_syncn
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_i};
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign ext_edge  = sync_q[SYNC_STAGES-1] ^ prev_q;
   assign ext_phase = sync_q[SYNC_STAGES-1] ^ clk_inv_i;

   always_comb begin
      if (ext_mode_i == SRC_EXT) begin
         lead_o  = run_i && ext_edge && ext_phase;
         trail_o = run_i && ext_edge && !ext_phase;
      end else begin
         lead_o  = int_tick && !phase_q;
         trail_o = int_tick && phase_q;
      end
   end

   assign phase_o = phase_q && (ext_mode_i == SRC_INT);

   // R7
   lead_trail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({lead_o, trail_o}));

   // R8
   idle_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> !(lead_o || trail_o));

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl #(
   parameter int unsigned WORD_W = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic clr_done_i,
   input  logic trail_i,
   output logic busy_o,
   output logic done_o
);
   import sio_pkg::*;

   localparam int unsigned CNT_W = cnt_width(WORD_W);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, done_q;
   logic             last_bit;

   assign last_bit = busy_q && trail_i && (cnt_q == CNT_W'(WORD_W - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q && start_i) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (busy_q && trail_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_bit) busy_q <= 1'b0;
         end
         if (last_bit)        done_q <= 1'b1;
         else if (clr_done_i) done_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;

   // R10
   done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_q) |-> $fell(busy_q));

   // R3
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_W'(WORD_W - 1));

endmodule

// File: rtl/sio_shreg.sv
module sio_shreg #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned NIB_W  = 4,
   parameter int unsigned ADDR_W = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              busy_i,
   input  logic              lead_i,
   input  logic              trail_i,
   input  logic              msb_first_i,
   input  logic              sin_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [NIB_W-1:0]  wdata_i,
   output logic [NIB_W-1:0]  rdata_o,
   output logic              sout_o
);
   import sio_pkg::*;

   localparam int unsigned NIB_CNT = WORD_W / NIB_W;

   logic [WORD_W-1:0] sh_q, sh_wr;
   logic              sout_q, top_bit;

   // host nibble writes, blocked during a transfer
   always_comb begin
      sh_wr = sh_q;
      for (int i = 0; i < NIB_CNT; i++) begin
         if (wr_en_i && !busy_i && (addr_i == ADDR_W'(i)))
            sh_wr[i*NIB_W +: NIB_W] = wdata_i;
      end
   end

   assign top_bit = (msb_first_i == ORD_MSB) ? sh_q[WORD_W-1] : sh_q[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q <= '0;
      end else if (trail_i) begin
         if (msb_first_i == ORD_MSB) sh_q <= {sh_q[WORD_W-2:0], sin_i};
         else                        sh_q <= {sin_i, sh_q[WORD_W-1:1]};
      end else begin
         sh_q <= sh_wr;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sout_q <= 1'b0;
      else if (lead_i) sout_q <= top_bit;
   end

   assign rdata_o = sh_q[addr_i*NIB_W +: NIB_W];
   assign sout_o  = sout_q;

   // R9
   busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && !trail_i) |=> $stable(sh_q));

   // R7
   sout_lead_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lead_i |=> $stable(sout_q));

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned NIB_W       = 4,
   parameter int unsigned HALF_DIV    = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ADDR_W     = sio_pkg::cnt_width(WORD_W / NIB_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ext_mode_i,
   input  logic              msb_first_i,
   input  logic              clk_inv_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [NIB_W-1:0]  wdata_i,
   output logic [NIB_W-1:0]  rdata_o,
   input  logic              start_i,
   input  logic              clr_done_i,
   output logic              busy_o,
   output logic              done_o,
   input  logic              sin_i,
   output logic              sout_o,
   input  logic              sclk_i,
   output logic              sclk_o,
   output logic              sclk_oe_o
);
   import sio_pkg::*;

   generate
      if (WORD_W % NIB_W != 0) begin : g_bad_nib
         $error("WORD_W must be a multiple of NIB_W");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic lead, trail, phase, busy;

   sio_clkgen #(
      .HALF_DIV    (HALF_DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_clkgen (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (busy),
      .ext_mode_i (ext_mode_i),
      .clk_inv_i  (clk_inv_i),
      .sclk_i     (sclk_i),
      .lead_o     (lead),
      .trail_o    (trail),
      .phase_o    (phase)
   );

   sio_ctrl #(
      .WORD_W (WORD_W)
   ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .clr_done_i (clr_done_i),
      .trail_i    (trail),
      .busy_o     (busy),
      .done_o     (done_o)
   );

   sio_shreg #(
      .WORD_W (WORD_W),
      .NIB_W  (NIB_W),
      .ADDR_W (ADDR_W)
   ) u_shreg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .busy_i      (busy),
      .lead_i      (lead),
      .trail_i     (trail),
      .msb_first_i (msb_first_i),
      .sin_i       (sin_i),
      .addr_i      (addr_i),
      .wr_en_i     (wr_en_i),
      .wdata_i     (wdata_i),
      .rdata_o     (rdata_o),
      .sout_o      (sout_o)
   );

   assign busy_o    = busy;
   assign sclk_o    = phase ^ clk_inv_i;
   assign sclk_oe_o = (ext_mode_i == SRC_INT);

   // R6
   idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy |-> (sclk_o == clk_inv_i));

endmodule

// File: tb/sio_shifter_test.sv
module sio_shifter_test;

   localparam int unsigned H     = 2;
   localparam int unsigned TOTAL = 16 * H + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_mode = 1'b0, msb_first = 1'b1, clk_inv = 1'b0;
   logic       addr = 1'b0, wr_en = 1'b0;
   logic [3:0] wdata = '0;
   logic [3:0] rdata;
   logic       start = 1'b0, clr_done = 1'b0;
   logic       busy, done;
   logic       sin = 1'b0, sout;
   logic       sclk_in = 1'b0, sclk_out, sclk_oe;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sio_shifter #(.WORD_W(8), .NIB_W(4), .HALF_DIV(H), .SYNC_STAGES(2)) uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ext_mode_i  (ext_mode),
      .msb_first_i (msb_first),
      .clk_inv_i   (clk_inv),
      .addr_i      (addr),
      .wr_en_i     (wr_en),
      .wdata_i     (wdata),
      .rdata_o     (rdata),
      .start_i     (start),
      .clr_done_i  (clr_done),
      .busy_o      (busy),
      .done_o      (done),
      .sin_i       (sin),
      .sout_o      (sout),
      .sclk_i      (sclk_in),
      .sclk_o      (sclk_out),
      .sclk_oe_o   (sclk_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic line_bit(input logic [7:0] w, input bit msb, input int k);
      return msb ? w[7-k] : w[k];
   endfunction

   task automatic write_word(input logic [7:0] w);
      @(negedge clk); addr = 1'b0; wdata = w[3:0]; wr_en = 1'b1;
      @(negedge clk); addr = 1'b1; wdata = w[7:4];
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic read_word(output logic [7:0] w);
      @(negedge clk); addr = 1'b0; #1 w[3:0] = rdata;
      addr = 1'b1; #1 w[7:4] = rdata;
   endtask

   task automatic t_reset;
      logic [7:0] w;
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 sout", sout, 0);
      check("R1 sclk idle", sclk_out, 0);
      read_word(w);
      check("R1 readback", w, 8'h00);
   endtask

   task automatic t_nibbles;
      logic [7:0] w;
      write_word(8'hC5);
      @(negedge clk); addr = 1'b0; #1 check("R2 low nibble", rdata, 4'h5);
      addr = 1'b1; #1 check("R2 high nibble", rdata, 4'hC);
      read_word(w);
      check("R2 word", w, 8'hC5);
   endtask

   task automatic t_internal(input bit msb, input bit inv, input logic [7:0] tx,
                             input logic [7:0] rx, input bit poke);
      string tag = msb ? "R4" : "R5";
      logic prev_s, prev_o;
      int leads = 0;
      int r7_bad = 0;
      logic [7:0] w;
      @(negedge clk); ext_mode = 1'b0; msb_first = msb; clk_inv = inv;
      @(negedge clk);
      check("R6 idle level", sclk_out, inv);
      check("R3 clock oe", sclk_oe, 1);
      write_word(tx);
      @(negedge clk); start = 1'b1;
      prev_s = sclk_out; prev_o = sout;
      for (int n = 1; n <= TOTAL; n++) begin
         @(negedge clk);
         start = 1'b0; wr_en = 1'b0;
         if (poke && n == 6) begin
            addr = 1'b0; wdata = ~tx[3:0]; wr_en = 1'b1; start = 1'b1;
         end
         if (sclk_out !== prev_s && sclk_out === ~inv) begin
            if (leads == 0) check("R3 first leading edge", n, H + 1);
            if (leads < 8) begin
               check({tag, " line bit"}, sout, line_bit(tx, msb, leads));
               sin = line_bit(rx, msb, leads);
            end
            leads++;
         end else if (sout !== prev_o) begin
            r7_bad++;
         end
         if (n == TOTAL - 1) check("R3 done not early", done, 0);
         if (n == TOTAL) begin
            check("R10 done set", done, 1);
            check("R10 busy clear", busy, 0);
            check("R10 clock idle", sclk_out, inv);
         end
         prev_s = sclk_out; prev_o = sout;
      end
      check("R6 leading edge count", leads, 8);
      check("R7 data only on leading edge", r7_bad, 0);
      read_word(w);
      check(poke ? "R9 write ignored" : {tag, " received word"}, w, rx);
   endtask

   task automatic t_done_clear;
      repeat (5) @(negedge clk);
      check("R10 done sticky", done, 1);
      clr_done = 1'b1;
      @(negedge clk); clr_done = 1'b0;
      check("R10 done cleared", done, 0);
   endtask

   task automatic t_external(input bit msb, input bit inv, input logic [7:0] tx,
                             input logic [7:0] rx);
      string tag = msb ? "R4" : "R5";
      logic [7:0] w;
      @(negedge clk); ext_mode = 1'b1; msb_first = msb; clk_inv = inv; sclk_in = inv;
      repeat (4) @(negedge clk);
      check("R8 clock oe", sclk_oe, 0);
      write_word(tx);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R10 start clears done", done, 0);
      repeat (2) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         sclk_in = ~inv;
         repeat (5) @(negedge clk);
         check({tag, " ext line bit"}, sout, line_bit(tx, msb, k));
         sin = line_bit(rx, msb, k);
         sclk_in = inv;
         if (k < 7) repeat (5) @(negedge clk);
      end
      repeat (2) @(negedge clk);
      check("R8 sync latency, done not yet", done, 0);
      @(negedge clk);
      check("R8 sync latency, done", done, 1);
      check("R8 busy clear", busy, 0);
      read_word(w);
      check({tag, " ext received word"}, w, rx);
      for (int k = 0; k < 4; k++) begin
         sclk_in = ~sclk_in;
         repeat (4) @(negedge clk);
      end
      read_word(w);
      check("R8 idle edges ignored", w, rx);
      check("R8 idle sout held", sout, line_bit(tx, msb, 7));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_nibbles();
      t_internal(1'b1, 1'b0, 8'hA6, 8'h3C, 1'b0);
      t_done_clear();
      t_internal(1'b0, 1'b0, 8'h81, 8'hE2, 1'b0);
      t_internal(1'b1, 1'b1, 8'h5B, 8'hC9, 1'b0);
      t_internal(1'b0, 1'b1, 8'h37, 8'h94, 1'b1);
      t_done_clear();
      t_external(1'b1, 1'b0, 8'hD2, 8'h6B);
      t_external(1'b0, 1'b1, 8'h1E, 8'hA5);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule